// File: doc/BRIEF.md
# Shared-Period Multi-Output PWM Timer

This block groups one period channel with a number of duty channels to drive several PWM pins that share a common period. The period channel is a down-counter that reloads itself. When it reaches zero it emits a period event and starts over, so the output period is (period value + 1) count ticks. A count tick is any clock cycle where `cnt_en` is high.

Each duty channel is a one-shot down-counter that the period event retriggers. On that event the channel loads its own duty value and its pin goes active. The pin goes inactive when the counter reaches zero, and the counter then waits for the next period event. The resulting duty is duty value / (period value + 1), and any duty value of period value + 1 or more holds the pin active for the whole period.

A host writes the values through a small write port into holding registers. Every counter samples the holding registers only at the period event, so a period value and duty values written between two events take effect together. A `start` pulse arms the group, and the first period event falls on the first count tick after `start`. A `stop` pulse freezes every counter and forces every pin inactive.

Top module: `mpwm_group`

## Requirements
- R1: After reset all pins are inactive, no interrupt pulse is raised, and the group stays idle until `start`.
- R2: Once started, `prd_irq` is a one-cycle pulse, one cycle after each period event. The first event falls on the first count tick after `start`, and each later event follows (period value + 1) count ticks after the previous one.
- R3: Counters change only on cycles with `cnt_en` high. With `cnt_en` low, no pin changes and no interrupt pulse is raised.
- R4: At each period event, duty channel k loads its duty value D. When D is nonzero, pin k is active from the cycle after the event for exactly D count ticks.
- R5: A duty channel raises its bit of `duty_irq` for one cycle when its counter reaches zero. This happens after counting down from one, or at the event when D is zero. A reload at the event that would otherwise have reached zero takes priority, and no pulse is raised then.
- R6: A duty value of period value + 1 or more keeps its pin continuously active.
- R7: A duty value of zero keeps its pin inactive for the whole period.
- R8: Writes only update holding registers, and counters sample them at a period event. A write in the cycle of an event takes effect at the following event.
- R9: `stop` forces every pin inactive, freezes every counter and silences every interrupt. Only `start` resumes operation, and it does so from a fresh period.
- R10: Write select 0 addresses the period value, and select k (1..NSLV) addresses duty channel k, which drives `pwm_out[k-1]` and `duty_irq[k-1]`. Any other select value is ignored.
- R11: When `start` and `stop` are high in the same cycle, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count tick enable |
| start | input | 1 | Arm the group, first period begins on next tick |
| stop | input | 1 | Freeze counters and force pins inactive |
| wr_en | input | 1 | Holding register write strobe |
| wr_sel | input | SEL_W (3) | 0 = period value, k = duty channel k |
| wr_data | input | CW (16) | Value written |
| prd_irq | output | 1 | Period event pulse |
| duty_irq | output | NSLV (6) | Per-channel zero-reached pulse |
| pwm_out | output | NSLV (6) | PWM pins, active high |

## Verification
A behavioural model runs beside the design, and pins and interrupts are compared on every cycle. With `cnt_en` held high and a fixed set of duty values (zero, one, mid-range, equal to the period, and above it), the checks separate correct duty lengths from off-by-one errors. They also separate saturated duty from wrap-around and confirm that a zero duty stays silent. A gapped enable pattern tells tick counting apart from cycle counting. Writes on every cycle with rotating selects, including an unused select, check the buffering at the period event. A mid-period stop and a start raised together with stop, followed by a zero-length period, test the control priorities.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int unsigned CNT_W = 16;

  typedef logic [CNT_W-1:0] cnt_t;

  // Next value of a down-counter that reloads on an event and parks at zero.
  function automatic cnt_t down_next(input logic reload, input cnt_t ld, input cnt_t cur);
    if (reload)          return ld;
    else if (cur != '0)  return cnt_t'(cur - cnt_t'(1));
    else                 return '0;
  endfunction

  // A counter reaches zero on this tick if it was live (or just loaded) and lands on zero.
  function automatic logic lands_zero(input logic reload, input cnt_t cur, input cnt_t nxt);
    return (reload || (cur != '0)) && (nxt == '0);
  endfunction
endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs #(
  parameter int unsigned NCH   = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [SEL_W-1:0]                    wr_sel,
  input  mpwm_pkg::cnt_t                      wr_data,
  output mpwm_pkg::cnt_t [NCH-1:0]            vals
);
  mpwm_pkg::cnt_t [NCH-1:0] hold_q;

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    hold_q[g] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))       hold_q[g] <= wr_data;
    end
  end

  assign vals = hold_q;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vals)); // R8
endmodule

// File: rtl/mpwm_master.sv
module mpwm_master (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic           start,
  input  logic           stop,
  input  mpwm_pkg::cnt_t period,
  output logic           run_o,
  output logic           evt_o,
  output logic           irq_o
);
  import mpwm_pkg::*;

  cnt_t mcnt_q;
  logic run_q, irq_q;
  logic tick;

  assign tick  = run_q && cnt_en && !start && !stop;
  assign evt_o = tick && (mcnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mcnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= evt_o;
      if (start) begin
        run_q  <= 1'b1;
        mcnt_q <= '0;
      end else if (stop) begin
        run_q  <= 1'b0;
      end else if (tick) begin
        mcnt_q <= down_next(evt_o, period, mcnt_q);
      end
    end
  end

  assign run_o = run_q;
  assign irq_o = irq_q;

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(cnt_en) && $past(run_o)); // R3

  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !start) |=> $stable(mcnt_q)); // R3
endmodule

// File: rtl/mpwm_slave.sv
module mpwm_slave (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic           start,
  input  logic           stop,
  input  logic           run_i,
  input  logic           evt_i,
  input  mpwm_pkg::cnt_t duty_i,
  output logic           pwm_o,
  output logic           irq_o
);
  import mpwm_pkg::*;

  cnt_t scnt_q, scnt_nx;
  logic irq_q, tick;

  assign tick    = run_i && cnt_en && !start && !stop;
  assign scnt_nx = down_next(evt_i, duty_i, scnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= tick && lands_zero(evt_i, scnt_q, scnt_nx);
      if (start)     scnt_q <= '0;
      else if (tick) scnt_q <= scnt_nx;
    end
  end

  assign pwm_o = run_i && (scnt_q != '0);
  assign irq_o = irq_q;

  AST_LOAD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && (duty_i != '0)) |=> pwm_o); // R4

  AST_FALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_o) && run_i && !$past(start)) |-> irq_o); // R5
endmodule

// File: rtl/mpwm_group.sv
module mpwm_group #(
  parameter int unsigned CW    = mpwm_pkg::CNT_W,
  parameter int unsigned NSLV  = 6,
  localparam int unsigned NCH  = NSLV + 1,
  localparam int unsigned SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              start,
  input  logic              stop,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [CW-1:0]     wr_data,
  output logic              prd_irq,
  output logic [NSLV-1:0]   duty_irq,
  output logic [NSLV-1:0]   pwm_out
);
  import mpwm_pkg::*;

  cnt_t [NCH-1:0] vals;
  logic run, prd_evt;

  mpwm_regs #(.NCH(NCH), .SEL_W(SEL_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(cnt_t'(wr_data)), .vals(vals)
  );

  mpwm_master i_master (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start), .stop(stop),
    .period(vals[0]), .run_o(run), .evt_o(prd_evt), .irq_o(prd_irq)
  );

  for (genvar k = 0; k < NSLV; k++) begin : g_slv
    mpwm_slave i_slv (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start), .stop(stop),
      .run_i(run), .evt_i(prd_evt), .duty_i(vals[k+1]),
      .pwm_o(pwm_out[k]), .irq_o(duty_irq[k])
    );
  end

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == '0)); // R9

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> (duty_irq == '0) && !prd_irq); // R1
endmodule

// File: tb/test_mpwm_group.sv
`timescale 1ns/1ps
module test_mpwm_group;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, start = 1'b0, stop = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic prd_irq;
  logic [NS-1:0] duty_irq, pwm_out;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state
  int  m_cnt = 0;
  int  s_cnt [NS];
  int  hold [NS+1];
  bit  m_run = 0;
  bit  e_mirq = 0;
  bit [NS-1:0] e_sirq = '0;
  int  hi_cnt [NS];
  int  mirq_cnt = 0;

  always #2.5 clk = ~clk;

  mpwm_group i_mpwm_group (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start), .stop(stop),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .prd_irq(prd_irq), .duty_irq(duty_irq), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_tick();
    bit evt;
    int nv;
    e_mirq = 0;
    e_sirq = '0;
    if (start) begin
      m_run = 1; m_cnt = 0;
      foreach (s_cnt[i]) s_cnt[i] = 0;
    end else if (stop) begin
      m_run = 0;
    end else if (m_run && cnt_en) begin
      evt = (m_cnt == 0);
      if (evt) begin e_mirq = 1; m_cnt = hold[0]; end
      else m_cnt = m_cnt - 1;
      for (int i = 0; i < NS; i++) begin
        if (evt) nv = hold[i+1];
        else if (s_cnt[i] > 0) nv = s_cnt[i] - 1;
        else nv = 0;
        if (nv == 0 && (evt || s_cnt[i] > 0)) e_sirq[i] = 1;
        s_cnt[i] = nv;
      end
    end
    if (wr_en && wr_sel <= 3'(NS)) hold[wr_sel] = wr_data;
  endtask

  task automatic compare();
    logic [NS-1:0] e_pwm;
    for (int i = 0; i < NS; i++) e_pwm[i] = m_run && (s_cnt[i] != 0);
    chk(prd_irq == e_mirq, "R2 prd_irq", prd_irq, e_mirq);
    chk(duty_irq == e_sirq, "R5 duty_irq", duty_irq, e_sirq);
    chk(pwm_out == e_pwm, "R4 pwm_out", pwm_out, e_pwm);
    for (int i = 0; i < NS; i++) hi_cnt[i] += pwm_out[i];
    mirq_cnt += prd_irq;
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input int sel, input int val);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 16'(val);
    step();
    wr_en = 0;
  endtask

  task automatic clr_stats();
    foreach (hi_cnt[i]) hi_cnt[i] = 0;
    mirq_cnt = 0;
  endtask

  initial begin
    foreach (s_cnt[i]) s_cnt[i] = 0;
    foreach (hold[i]) hold[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pwm_out == '0, "R1 pins", pwm_out, 0);
    chk(duty_irq == '0 && !prd_irq, "R1 irqs", duty_irq, 0);
    rst_n = 1;
    @(negedge clk);
    cnt_en = 1;
    repeat (5) step();
    chk(pwm_out == '0, "R1 idle before start", pwm_out, 0);

    // R10 select map, R6/R7 duty set: period 9, duties 3,0,10,12,1,9
    wr(0, 9); wr(1, 3); wr(2, 0); wr(3, 10); wr(4, 12); wr(5, 1); wr(6, 9);
    wr(7, 2); // unused select, ignored (R10)
    start = 1; step(); start = 0;
    repeat (25) step();
    clr_stats();
    repeat (10) step();
    chk(mirq_cnt == 1, "R2 one event per period", mirq_cnt, 1);
    chk(hi_cnt[0] == 3, "R4 duty 3", hi_cnt[0], 3);
    chk(hi_cnt[1] == 0, "R7 duty zero", hi_cnt[1], 0);
    chk(hi_cnt[2] == 10, "R6 duty equal period", hi_cnt[2], 10);
    chk(hi_cnt[3] == 10, "R6 duty above period", hi_cnt[3], 10);
    chk(hi_cnt[4] == 1, "R4 duty 1", hi_cnt[4], 1);

    // R3: gapped enable
    for (int i = 0; i < 60; i++) begin
      cnt_en = (i % 3) != 0;
      step();
    end
    cnt_en = 0;
    clr_stats();
    repeat (8) step();
    chk(mirq_cnt == 0, "R3 no event without enable", mirq_cnt, 0);
    cnt_en = 1;

    // R8/R10: writes every cycle, rotating selects including unused 7
    for (int i = 0; i < 80; i++) begin
      wr_en = 1; wr_sel = 3'(i % 8); wr_data = 16'((i * 5) % 7);
      step();
    end
    wr_en = 0;
    repeat (20) step();

    // R9: stop mid-period, then hold
    wr(0, 11); wr(1, 6);
    repeat (15) step();
    stop = 1; step(); stop = 0;
    clr_stats();
    repeat (10) step();
    chk(hi_cnt[2] == 0 && mirq_cnt == 0, "R9 frozen after stop", hi_cnt[2], 0);

    // R11: start and stop together, then zero-length period
    start = 1; stop = 1; step(); start = 0; stop = 0;
    repeat (30) step();
    wr(0, 0);
    repeat (20) step();
    clr_stats();
    repeat (5) step();
    chk(mirq_cnt == 5, "R2 period value zero", mirq_cnt, 5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule